// File: doc/BRIEF.md
# Backplane Window Address Translator

This block sits on the host side of a serial link to a wireless device. Software hands it a 32-bit address on the device's internal bus, together with write data, a byte count and a direction. A command on the link can carry only 17 address bits, so the block splits the address in two. The upper 17 bits form a window, which the device holds in three byte-wide registers. The lower 15 bits form an offset that goes into the data command.

The block keeps a copy of the window it last programmed. For each request it compares the three window bytes with that copy, most significant byte first. For each byte that differs it emits a one-byte register write, and then it emits the data command. Each command goes out as a descriptor on a valid/ready stream to a downstream serial engine.

On the request side, a request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no request is in progress. On the command side, a descriptor is held unchanged until it is taken in a cycle with `cmd_valid` and `cmd_ready` both high. The engine may hold `cmd_ready` low for as long as it needs. A one-cycle `done` pulse marks the end of each request, and `invalidate` makes the block forget the window it has cached.

Top module: `bpwin_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `cmd_valid` is 0 and `done` is 0.
- R2: For each window byte that differs from the cache, one write command is emitted, in the order high byte, mid byte, low byte. The high byte is window bits 31:24 at register 0x1000C, the mid byte is bits 23:16 at 0x1000B, and the low byte is bits 15:8 at 0x1000A. Each such command has write=1, incr=1, func=1 and len=1, and carries the byte in `cmd_data[7:0]` with all other data bits 0.
- R3: After reset, the cached window is 0xAAAAAAAA.
- R4: The window is the request address with bits 14:0 cleared. After a request, the cache holds that window, so a later request in the same window emits only its data command.
- R5: The data command follows the window writes. It has func=1, incr=1, `cmd_write` equal to the request's direction, `cmd_len` equal to the request length and `cmd_data` equal to the request data. In `cmd_addr`, bits 14:0 are the address bits 14:0 and bit 16 is 0.
- R6: Bit 15 of the data command's `cmd_addr` is 1 exactly when the request length is 4.
- R7: While `cmd_valid` is high and `cmd_ready` is low, the descriptor does not change. `req_ready` is low from the cycle after a request is taken until the cycle after its data command is taken.
- R8: `done` is high for exactly one cycle, the cycle after the data command is taken, and at no other time.
- R9: When `invalidate` is high at a clock edge, the cache returns to 0xAAAAAAAA. This takes priority over loading the window of a request taken at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| invalidate | input | 1 | Resets the cached window to its reset pattern |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Internal bus address |
| req_wdata | input | 32 | Write data |
| req_len | input | 11 | Access length in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| cmd_valid | output | 1 | Command descriptor present |
| cmd_ready | input | 1 | Engine takes the descriptor |
| cmd_write | output | 1 | Command direction |
| cmd_incr | output | 1 | Incrementing-address bit |
| cmd_func | output | 2 | Function number |
| cmd_addr | output | 17 | Command address |
| cmd_len | output | 11 | Command length in bytes |
| cmd_data | output | 32 | Command data |
| done | output | 1 | Request finished (one-cycle pulse) |

## Verification
A corrupted cache cannot be seen until the next request. That request then shows a window write that should not be there, or lacks one that should. The error appears in the first descriptor of that request, so the bench runs requests that stay in one window and requests that move between windows. A wrong byte index or wrong ordering shows up as a wrong register address or data byte inside the same request. A lost handshake shows up as a missing or late `done`, which the per-cycle comparison catches in the cycle it occurs.

// File: rtl/bpwin_pkg.sv
`timescale 1ns/1ps
package bpwin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIN  = 2'd1,
    ST_DATA = 2'd2
  } bpw_state_e;

  localparam logic [1:0] FUNC_BACKPLANE = 2'd1;
endpackage

// File: rtl/bpwin_cache.sv
`timescale 1ns/1ps
module bpwin_cache #(
  parameter int ADDR_W = 32,
  parameter int OFS_W = 15,
  parameter int NB = 3,
  parameter logic [ADDR_W-1:0] RESET_WIN = 32'hAAAA_AAAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inval,
  input  logic              load,
  input  logic [ADDR_W-1:0] new_win,
  output logic [NB-1:0]     diff
);
  localparam int BYTE_LSB = ADDR_W - 8 * NB;

  logic [ADDR_W-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst || inval) win_q <= RESET_WIN;
    else if (load)    win_q <= new_win;
  end

  for (genvar i = 0; i < NB; i++) begin : g_cmp
    assign diff[i] = win_q[BYTE_LSB + 8*i +: 8] != new_win[BYTE_LSB + 8*i +: 8];
  end
endmodule

// File: rtl/bpwin_seq.sv
`timescale 1ns/1ps
module bpwin_seq
  import bpwin_pkg::*;
#(
  parameter int NB = 3,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [NB-1:0]    diff,
  input  logic             cmd_ready,
  output logic             req_ready,
  output logic             accept,
  output logic             cmd_valid,
  output bpw_state_e       state,
  output logic [IDX_W-1:0] cur_idx,
  output logic             done
);
  logic [NB-1:0] pend_q;
  logic [NB-1:0] pend_nx;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cmd_valid = (state != ST_IDLE);

  // The highest pending byte goes first.
  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < NB; i++)
      if (pend_q[i]) cur_idx = IDX_W'(i);
  end

  always_comb begin
    pend_nx = pend_q;
    pend_nx[cur_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      pend_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          pend_q <= diff;
          state  <= (|diff) ? ST_WIN : ST_DATA;
        end
        ST_WIN: if (cmd_ready) begin
          pend_q <= pend_nx;
          if (pend_nx == '0) state <= ST_DATA;
        end
        ST_DATA: if (cmd_ready) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bpwin_xlate.sv
`timescale 1ns/1ps
module bpwin_xlate
  import bpwin_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W = 11,
  parameter int OFS_W = 15,
  parameter int CMD_ADDR_W = 17,
  parameter logic [CMD_ADDR_W-1:0] WIN_REG_BASE = 17'h1000A,
  parameter int WIDE_LEN = 4,
  parameter logic [ADDR_W-1:0] RESET_WIN = 32'hAAAA_AAAA
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  invalidate,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [LEN_W-1:0]      req_len,
  input  logic                  req_write,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic                  cmd_write,
  output logic                  cmd_incr,
  output logic [1:0]            cmd_func,
  output logic [CMD_ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]      cmd_len,
  output logic [DATA_W-1:0]     cmd_data,
  output logic                  done
);
  localparam int NB = (ADDR_W - OFS_W + 7) / 8;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int BYTE_LSB = ADDR_W - 8 * NB;
  localparam logic [CMD_ADDR_W-1:0] WIDE_FLAG = CMD_ADDR_W'(1) << OFS_W;

  logic              accept;
  logic [NB-1:0]     diff;
  bpw_state_e        state;
  logic [IDX_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] new_win;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LEN_W-1:0]  len_q;
  logic              write_q;
  logic [ADDR_W-1:0] win_l;
  logic [7:0]        win_byte;
  logic [CMD_ADDR_W-1:0] data_addr;

  assign new_win = {req_addr[ADDR_W-1:OFS_W], OFS_W'(0)};
  assign win_l   = {addr_q[ADDR_W-1:OFS_W], OFS_W'(0)};

  bpwin_cache #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .NB(NB), .RESET_WIN(RESET_WIN)
  ) cache_i (
    .clk(clk), .rst(rst), .inval(invalidate), .load(accept),
    .new_win(new_win), .diff(diff)
  );

  bpwin_seq #(.NB(NB)) seq_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .diff(diff),
    .cmd_ready(cmd_ready), .req_ready(req_ready), .accept(accept),
    .cmd_valid(cmd_valid), .state(state), .cur_idx(cur_idx), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      len_q   <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      len_q   <= req_len;
      write_q <= req_write;
    end
  end

  assign win_byte  = win_l[BYTE_LSB + 8*int'(cur_idx) +: 8];
  assign data_addr = CMD_ADDR_W'(addr_q[OFS_W-1:0])
                   | ((len_q == LEN_W'(WIDE_LEN)) ? WIDE_FLAG : '0);

  always_comb begin
    cmd_write = 1'b0;
    cmd_incr  = 1'b0;
    cmd_func  = 2'd0;
    cmd_addr  = '0;
    cmd_len   = '0;
    cmd_data  = '0;
    unique case (state)
      ST_WIN: begin
        cmd_write = 1'b1;
        cmd_incr  = 1'b1;
        cmd_func  = FUNC_BACKPLANE;
        cmd_addr  = WIN_REG_BASE + CMD_ADDR_W'(cur_idx);
        cmd_len   = LEN_W'(1);
        cmd_data  = DATA_W'(win_byte);
      end
      ST_DATA: begin
        cmd_write = write_q;
        cmd_incr  = 1'b1;
        cmd_func  = FUNC_BACKPLANE;
        cmd_addr  = data_addr;
        cmd_len   = len_q;
        cmd_data  = wdata_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bpwin_chk.sv
`timescale 1ns/1ps
module bpwin_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        cmd_write,
  input logic        cmd_incr,
  input logic [1:0]  cmd_func,
  input logic [16:0] cmd_addr,
  input logic [10:0] cmd_len,
  input logic [31:0] cmd_data,
  input logic        done
);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_data)
      && $stable(cmd_len) && $stable(cmd_write));

  p_busy_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !req_ready);

  p_winfmt_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_addr[16] |-> cmd_write && cmd_len == 11'd1 && cmd_data[31:8] == 24'd0);

  p_func_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_func == 2'd1 && cmd_incr);

  p_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(cmd_valid && cmd_ready && !cmd_addr[16]));

  p_donepulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind bpwin_xlate bpwin_chk chk_i (
  .clk(clk), .rst(rst), .req_ready(req_ready), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_incr(cmd_incr),
  .cmd_func(cmd_func), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
  .cmd_data(cmd_data), .done(done)
);

// File: tb/bpwin_xlate_tb_top.sv
`timescale 1ns/1ps
module bpwin_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        invalidate = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [10:0] req_len = '0;
  logic        req_write = 1'b0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic        cmd_write;
  logic        cmd_incr;
  logic [1:0]  cmd_func;
  logic [16:0] cmd_addr;
  logic [10:0] cmd_len;
  logic [31:0] cmd_data;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bpwin_xlate dut_i (
    .clk(clk), .rst(rst), .invalidate(invalidate),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_len(req_len), .req_write(req_write),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_incr(cmd_incr), .cmd_func(cmd_func), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_data(cmd_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model
  logic [63:0] expq[$];
  logic [31:0] m_cache = 32'hAAAA_AAAA;
  bit          busy = 1'b0;
  bit          exp_done = 1'b0;
  int          done_cnt = 0;

  function automatic logic [63:0] pack(bit w, logic [16:0] a, logic [10:0] l, logic [31:0] d);
    return {w, 1'b1, 2'b01, a, l, d};
  endfunction

  task automatic build(input logic [31:0] a, input logic [31:0] d, input logic [10:0] l, input bit w);
    logic [31:0] win;
    logic [16:0] da;
    win = a & 32'hFFFF_8000;
    for (int b = 2; b >= 0; b--)
      if (win[8+8*b +: 8] != m_cache[8+8*b +: 8])
        expq.push_back(pack(1'b1, 17'h1000A + 17'(b), 11'd1, {24'd0, win[8+8*b +: 8]}));
    da = {2'b00, a[14:0]};
    if (l == 11'd4) da[15] = 1'b1;
    expq.push_back(pack(w, da, l, d));
    m_cache = win;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(done == exp_done, "R8 done timing", 64'(done), 64'(exp_done));
      chk(req_ready == !busy, "R7 req_ready", 64'(req_ready), 64'(!busy));
      if (done) done_cnt++;
      exp_done = 1'b0;
      if (req_valid && req_ready) begin
        build(req_addr, req_wdata, req_len, req_write);
        busy = 1'b1;
      end
      if (cmd_valid && cmd_ready) begin
        logic [63:0] act, exp;
        act = {cmd_write, cmd_incr, cmd_func, cmd_addr, cmd_len, cmd_data};
        if (expq.size() == 0) begin
          chk(1'b0, "R2 R5 unexpected command", act, 64'd0);
        end else begin
          exp = expq.pop_front();
          chk(act == exp, exp[59] ? "R2 window byte write" : "R5 R6 data command", act, exp);
          if (expq.size() == 0) begin
            busy = 1'b0;
            exp_done = 1'b1;
          end
        end
      end
      if (invalidate) m_cache = 32'hAAAA_AAAA;
    end
  end

  // Back-pressure pattern from an LFSR
  logic [7:0] lfsr = 8'h5B;
  bit         full_ready = 1'b0;
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_ready = full_ready | lfsr[0] | lfsr[1];
    end
  end

  task automatic do_req(input logic [31:0] a, input logic [31:0] d, input logic [10:0] l,
                        input bit w, input bit inv);
    int target;
    target = done_cnt + 1;
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_wdata = d; req_len = l; req_write = w;
    invalidate = inv;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0; invalidate = 1'b0;
    while (done_cnt < target) @(negedge clk);
  endtask

  task automatic pulse_inval();
    @(posedge clk); #1; invalidate = 1'b1;
    @(posedge clk); #1; invalidate = 1'b0;
  endtask

  task automatic finish_run();
    chk(expq.size() == 0, "R5 leftover expected commands", 64'(expq.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R1 reset outputs",
        {61'd0, req_ready, cmd_valid, done}, 64'h4);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R1 after reset",
        {61'd0, req_ready, cmd_valid, done}, 64'h4);
    // R3: first access compared with the reset pattern, all three bytes differ
    do_req(32'h1800_4010, 32'h0000_0003, 11'd4, 1'b1, 1'b0);
    // R4: same window, data command only
    do_req(32'h1800_4044, 32'h0000_0000, 11'd4, 1'b1, 1'b0);
    // only the low byte changes; length 2 leaves bit 15 clear (R6)
    do_req(32'h1800_8000, 32'hDEAD_BEEF, 11'd2, 1'b0, 1'b0);
    do_req(32'hAAAA_1234, 32'h1234_5678, 11'd1, 1'b1, 1'b0);
    // R9: after invalidate, high and mid bytes match the reset pattern
    pulse_inval();
    do_req(32'hAAAA_0000, 32'h0000_00FF, 11'd4, 1'b0, 1'b0);
    // R9: invalidate on the accept edge wins over the window load
    do_req(32'hAAAA_0008, 32'h0000_0001, 11'd4, 1'b1, 1'b1);
    do_req(32'hAAAA_000C, 32'h0000_0002, 11'd4, 1'b1, 1'b0);
    full_ready = 1'b1;
    do_req(32'h0001_FFFF, 32'hCAFE_F00D, 11'd4, 1'b1, 1'b0);
    do_req(32'hFFFF_7FFC, 32'h0BAD_CAFE, 11'd8, 1'b0, 1'b0);
    do_req(32'hFFFF_0000, 32'h0000_0000, 11'd4, 1'b0, 1'b0);
    full_ready = 1'b0;
    for (int k = 0; k < 8; k++)
      do_req(32'h1000_0000 + 32'(k) * 32'h0040_4000, 32'(k), (k % 2 == 0) ? 11'd4 : 11'd64,
             k[0], 1'b0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule